// File: doc/BRIEF.md
# Double-Buffered BCD Calendar Clock

This block keeps time of day and calendar date as packed BCD bytes: century, year, month, date, day of week, hours, minutes and seconds. A one-cycle `tick` pulse, arriving once per second, advances the seconds. Carries ripple through the minutes, the 24-hour hours, the day of week and the date. The date rolls over at each month's true length, including 29 February in leap years, and carries on through the month, the year and the century.

The registers form a window at the eight highest byte addresses of a 128K x 8 byte space. Any other address selected on the bus raises `ramSel` so that an external RAM can answer. The bus never touches the live counters directly. Reads come from a snapshot copy, which follows the counters unless software freezes it with the read-hold bit. Writes go into a holding copy while the write-hold bit is set. Clearing that bit loads the whole holding copy into the counters in one cycle. The counters advance on every tick whatever the bus is doing. When `pwrGood` is low the block ignores all bus cycles and drives no data, but it keeps counting.

Top module: `cal_clock_top`

## Requirements
- R1: After reset the clock reads century 20, year 00, month 01, date 01, day 1, 00:00:00, with both hold bits clear. The control byte therefore reads 0x20.
- R2: Each `tick` adds one second. Seconds and minutes count 00 to 59 in BCD and hours count 00 to 23, each carrying into the next field when it wraps.
- R3: The date wraps to 01 after 30 in months 04, 06, 09 and 11, after 31 in the other months, and in month 02 after 29 when the year digits are divisible by 4 and after 28 otherwise. Each wrap advances the month, and month 12 wraps to 01.
- R4: Year 99 wraps to 00 and adds one to the century. The century counts 00 to 39 in BCD and wraps to 00.
- R5: The day of week counts 1 to 7, wraps to 1, and advances together with the date at midnight.
- R6: The window addresses are 0x1FFF8 (control), 0x1FFF9 seconds, 0x1FFFA minutes, 0x1FFFB hours, 0x1FFFC day, 0x1FFFD date, 0x1FFFE month and 0x1FFFF year. A selected access below 0x1FFF8 raises `ramSel` combinationally and returns no data from the block.
- R7: A window read returns its byte on `rdData`, with `dataOe` high, in the cycle after the clock edge that samples the read. The control byte is laid out as bit 7 write-hold, bit 6 read-hold and bits 5:0 century in BCD.
- R8: While read-hold is set, reads return a frozen snapshot even as ticks arrive. While it is clear, the snapshot copies the counters on every cycle, so reads reflect a change two edges after it occurs.
- R9: Setting write-hold copies the counters into the holding copy. Writes to time fields then update only the holding copy, and the counters keep advancing. Writes to time fields while write-hold is clear are ignored.
- R10: A control write that clears write-hold loads every field of the holding copy into the counters in one cycle. This includes the century bits carried in that same write, and the load takes precedence over a coincident tick.
- R11: While `pwrGood` is low, reads and writes are ignored, `dataOe` and `ramSel` stay low, and the counters still advance on each tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse, once per second |
| pwrGood | input | 1 | Supply in tolerance; low blocks all bus cycles |
| chipSel | input | 1 | Bus select |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe (wins over a read in the same cycle) |
| addr | input | 17 | Byte address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, zero when no read is answered |
| dataOe | output | 1 | Read data valid and driven |
| ramSel | output | 1 | Access falls below the register window |

## Verification
Read data is due in the cycle after the edge that samples the read strobe. The monitor therefore samples `dataOe` and `rdData` at the falling edge that follows, in the same order the driver queued its expected bytes. A tick or a committed write reaches the counters at the next edge and the snapshot one edge later, so the driver waits three idle cycles after every tick or commit before it reads. `ramSel` is combinational and is checked one nanosecond after the inputs change. The absence of read data is checked at the falling edge where a reply would otherwise appear.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int BYTE_W   = 8;
  localparam int NUM_REGS = 8;
  localparam int IDX_W    = $clog2(NUM_REGS);

  localparam int IX_CENT  = 0;
  localparam int IX_SEC   = 1;
  localparam int IX_MIN   = 2;
  localparam int IX_HOUR  = 3;
  localparam int IX_DAY   = 4;
  localparam int IX_DATE  = 5;
  localparam int IX_MONTH = 6;
  localparam int IX_YEAR  = 7;

  typedef logic [BYTE_W-1:0] bcdByte_t;

  typedef struct packed {
    logic             holdWr;
    logic             capture;
    logic             commit;
    logic [IDX_W-1:0] wrIdx;
    bcdByte_t         wrByte;
    logic [IDX_W-1:0] rdIdx;
  } dpStrobe_t;

  function automatic bcdByte_t bcdInc(bcdByte_t v, bcdByte_t top, bcdByte_t floorVal);
    if (v == top) return floorVal;
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  function automatic logic isLeap(bcdByte_t yr);
    logic [6:0] bin;
    bin = {3'b000, yr[7:4]} * 7'd10 + {3'b000, yr[3:0]};
    return bin[1:0] == 2'b00;
  endfunction

  function automatic bcdByte_t monthEnd(bcdByte_t mon, bcdByte_t yr);
    case (mon)
      8'h02:                      return isLeap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic bcdByte_t resetVal(int ix);
    case (ix)
      IX_CENT:  return 8'h20;
      IX_DAY:   return 8'h01;
      IX_DATE:  return 8'h01;
      IX_MONTH: return 8'h01;
      default:  return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      tick,
  input  dpStrobe_t strobe,
  input  logic      freezeSnap,
  output bcdByte_t  snapByte
);
  bcdByte_t cnt     [NUM_REGS];
  bcdByte_t cntNext [NUM_REGS];
  bcdByte_t hold    [NUM_REGS];
  bcdByte_t holdMux [NUM_REGS];
  bcdByte_t snap    [NUM_REGS];

  logic secTop, minTop, hourTop, dateTop, monTop, yearTop, midnight;

  assign secTop   = cnt[IX_SEC]   == 8'h59;
  assign minTop   = cnt[IX_MIN]   == 8'h59;
  assign hourTop  = cnt[IX_HOUR]  == 8'h23;
  assign dateTop  = cnt[IX_DATE]  == monthEnd(cnt[IX_MONTH], cnt[IX_YEAR]);
  assign monTop   = cnt[IX_MONTH] == 8'h12;
  assign yearTop  = cnt[IX_YEAR]  == 8'h99;
  assign midnight = secTop && minTop && hourTop;

  // holding copy after this cycle's capture and write
  always_comb begin
    for (int i = 0; i < NUM_REGS; i++) begin
      holdMux[i] = strobe.capture ? cnt[i] : hold[i];
    end
    if (strobe.holdWr) holdMux[strobe.wrIdx] = strobe.wrByte;
  end

  // carry chain of the calendar
  always_comb begin
    for (int i = 0; i < NUM_REGS; i++) cntNext[i] = cnt[i];
    if (tick) begin
      cntNext[IX_SEC] = bcdInc(cnt[IX_SEC], 8'h59, 8'h00);
      if (secTop) cntNext[IX_MIN] = bcdInc(cnt[IX_MIN], 8'h59, 8'h00);
      if (secTop && minTop) cntNext[IX_HOUR] = bcdInc(cnt[IX_HOUR], 8'h23, 8'h00);
      if (midnight) begin
        cntNext[IX_DAY]  = bcdInc(cnt[IX_DAY], 8'h07, 8'h01);
        cntNext[IX_DATE] = dateTop ? 8'h01 : bcdInc(cnt[IX_DATE], 8'h31, 8'h01);
        if (dateTop) cntNext[IX_MONTH] = bcdInc(cnt[IX_MONTH], 8'h12, 8'h01);
        if (dateTop && monTop) cntNext[IX_YEAR] = bcdInc(cnt[IX_YEAR], 8'h99, 8'h00);
        if (dateTop && monTop && yearTop)
          cntNext[IX_CENT] = bcdInc(cnt[IX_CENT], 8'h39, 8'h00);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        cnt[i]  <= resetVal(i);
        hold[i] <= resetVal(i);
      end
    end else begin
      for (int i = 0; i < NUM_REGS; i++) begin
        cnt[i] <= strobe.commit ? holdMux[i] : cntNext[i];
        if (strobe.holdWr || strobe.capture) hold[i] <= holdMux[i];
      end
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : gSnap
    always_ff @(posedge clk) begin
      if (!rstN) snap[g] <= resetVal(g);
      else if (!freezeSnap) snap[g] <= cnt[g];
    end
  end

  assign snapByte = snap[strobe.rdIdx];

  // R2
  sec_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !strobe.commit) |=> (cnt[IX_SEC] != $past(cnt[IX_SEC])));

  // R5
  dow_midnight_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !strobe.commit && midnight) |=> (cnt[IX_DAY] != $past(cnt[IX_DAY])));

  // R10
  commit_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> (cnt[IX_SEC] == $past(holdMux[IX_SEC]) &&
                       cnt[IX_CENT] == $past(holdMux[IX_CENT])));

  // R8
  snap_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    !freezeSnap |=> (snap[IX_SEC] == $past(cnt[IX_SEC])));
endmodule

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pwrGood,
  input  logic              chipSel,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  bcdByte_t          wrData,
  input  bcdByte_t          snapByte,
  output dpStrobe_t         strobe,
  output logic              freezeSnap,
  output bcdByte_t          rdData,
  output logic              dataOe,
  output logic              ramSel
);
  logic             wBit, rBit;
  logic             access, inWin, winWr, winRd, isCtrl, newW;
  logic [IDX_W-1:0] idx;

  assign access = chipSel && pwrGood;
  assign inWin  = &addr[ADDR_W-1:IDX_W];
  assign idx    = addr[IDX_W-1:0];
  assign isCtrl = idx == IDX_W'(IX_CENT);
  assign winWr  = access && inWin && wrEn;
  assign winRd  = access && inWin && rdEn && !wrEn;
  assign ramSel = access && !inWin;
  assign newW   = wrData[7];

  always_comb begin
    strobe.capture = winWr && isCtrl && !wBit && newW;
    strobe.commit  = winWr && isCtrl && wBit && !newW;
    strobe.holdWr  = winWr && (isCtrl ? (wBit || newW) : wBit);
    strobe.wrIdx   = idx;
    strobe.wrByte  = isCtrl ? {2'b00, wrData[5:0]} : wrData;
    strobe.rdIdx   = idx;
  end

  assign freezeSnap = rBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wBit   <= 1'b0;
      rBit   <= 1'b0;
      dataOe <= 1'b0;
      rdData <= '0;
    end else begin
      if (winWr && isCtrl) begin
        wBit <= newW;
        rBit <= wrData[6];
      end
      dataOe <= winRd;
      if (winRd) rdData <= isCtrl ? {wBit, rBit, snapByte[5:0]} : snapByte;
      else       rdData <= '0;
    end
  end

  // R11
  read_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> $past(pwrGood));

  // R7
  read_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> $past(chipSel && rdEn));
endmodule

// File: rtl/cal_clock_top.sv
module cal_clock_top
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              pwrGood,
  input  logic              chipSel,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  output logic              dataOe,
  output logic              ramSel
);
  dpStrobe_t strobe;
  logic      freezeSnap;
  bcdByte_t  snapByte;

  rtc_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .pwrGood(pwrGood), .chipSel(chipSel),
    .rdEn(rdEn), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .snapByte(snapByte), .strobe(strobe), .freezeSnap(freezeSnap),
    .rdData(rdData), .dataOe(dataOe), .ramSel(ramSel)
  );

  rtc_datapath i_dp (
    .clk(clk), .rstN(rstN), .tick(tick), .strobe(strobe),
    .freezeSnap(freezeSnap), .snapByte(snapByte)
  );
endmodule

// File: tb/test_cal_clock_top.sv
module test_cal_clock_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic        pwrGood = 1'b1;
  logic        chipSel = 1'b0;
  logic        rdEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [16:0] addr = '0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic        dataOe;
  logic        ramSel;

  int nChecks = 0;
  int nFails  = 0;
  logic [7:0] expQ[$];
  string      tagQ[$];

  localparam logic [16:0] WIN = 17'h1FFF8;

  cal_clock_top i_cal_clock_top (
    .clk(clk), .rstN(rstN), .tick(tick), .pwrGood(pwrGood), .chipSel(chipSel),
    .rdEn(rdEn), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .dataOe(dataOe), .ramSel(ramSel)
  );

  always #2.5 clk = ~clk;

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected byte for every answered read
  always @(negedge clk) begin
    if (rstN && dataOe) begin
      if (expQ.size() == 0) check("R7 unexpected read data", 8'h01, 8'h00);
      else check(tagQ.pop_front(), rdData, expQ.pop_front());
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse;
    tick = 1'b1; @(negedge clk); tick = 1'b0;
  endtask

  task automatic busWrite(logic [2:0] ix, logic [7:0] d);
    addr = WIN | {14'd0, ix}; wrData = d; chipSel = 1'b1; wrEn = 1'b1;
    @(negedge clk);
    chipSel = 1'b0; wrEn = 1'b0;
  endtask

  task automatic busRead(logic [2:0] ix, logic [7:0] exp, string tag);
    expQ.push_back(exp); tagQ.push_back(tag);
    addr = WIN | {14'd0, ix}; chipSel = 1'b1; rdEn = 1'b1;
    @(negedge clk);
    chipSel = 1'b0; rdEn = 1'b0;
  endtask

  task automatic readNone(logic [2:0] ix, string tag);
    addr = WIN | {14'd0, ix}; chipSel = 1'b1; rdEn = 1'b1;
    @(negedge clk);
    chipSel = 1'b0; rdEn = 1'b0;
    #1 check(tag, {7'd0, dataOe}, 8'h00);
  endtask

  task automatic setTime(logic [7:0] c, logic [7:0] y, logic [7:0] mo, logic [7:0] dt,
                         logic [7:0] dw, logic [7:0] h, logic [7:0] mi, logic [7:0] s);
    busWrite(3'd0, 8'h80 | c);
    busWrite(3'd1, s); busWrite(3'd2, mi); busWrite(3'd3, h);
    busWrite(3'd4, dw); busWrite(3'd5, dt); busWrite(3'd6, mo); busWrite(3'd7, y);
    busWrite(3'd0, c);
    idle(3);
  endtask

  task automatic readAll(logic [7:0] c, logic [7:0] y, logic [7:0] mo, logic [7:0] dt,
                         logic [7:0] dw, logic [7:0] h, logic [7:0] mi, logic [7:0] s,
                         string tag);
    busRead(3'd0, c, tag);  busRead(3'd1, s, tag);  busRead(3'd2, mi, tag);
    busRead(3'd3, h, tag);  busRead(3'd4, dw, tag); busRead(3'd5, dt, tag);
    busRead(3'd6, mo, tag); busRead(3'd7, y, tag);
    idle(2);
  endtask

  initial begin
    #(5ns * 100000);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    idle(4);
    rstN = 1'b1;
    idle(2);
    // R1 reset state
    readAll(8'h20, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, "R1 reset");

    // R2 one tick adds a second
    pulse(); idle(3);
    busRead(3'd1, 8'h01, "R2 first tick"); idle(2);

    // R9 holding copy written while counters keep running
    busWrite(3'd0, 8'hA0);
    busWrite(3'd1, 8'h59); busWrite(3'd2, 8'h59); busWrite(3'd3, 8'h23);
    busWrite(3'd4, 8'h07); busWrite(3'd5, 8'h28); busWrite(3'd6, 8'h02); busWrite(3'd7, 8'h23);
    pulse(); idle(3);
    busRead(3'd1, 8'h02, "R9 counters advance under write-hold");
    busRead(3'd0, 8'h80 | 8'h20, "R7 control byte with write-hold");
    idle(2);
    // R10 clearing write-hold commits the holding copy
    busWrite(3'd0, 8'h20); idle(3);
    readAll(8'h20, 8'h23, 8'h02, 8'h28, 8'h07, 8'h23, 8'h59, 8'h59, "R10 commit");

    // R3 R5 R2 non-leap February into March, day 7 wraps to 1
    pulse(); idle(3);
    readAll(8'h20, 8'h23, 8'h03, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, "R3 R5 Feb28 nonleap");

    // R3 leap February 28 goes to 29
    setTime(8'h20, 8'h24, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
    pulse(); idle(3);
    busRead(3'd5, 8'h29, "R3 leap Feb29"); busRead(3'd6, 8'h02, "R3 leap month");
    busRead(3'd4, 8'h04, "R5 day advance"); idle(2);
    // R3 leap February 29 goes to March 1
    setTime(8'h20, 8'h24, 8'h02, 8'h29, 8'h04, 8'h23, 8'h59, 8'h59);
    pulse(); idle(3);
    busRead(3'd5, 8'h01, "R3 Feb29 end"); busRead(3'd6, 8'h03, "R3 to March"); idle(2);
    // R3 thirty-day month
    setTime(8'h20, 8'h24, 8'h04, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59);
    pulse(); idle(3);
    busRead(3'd5, 8'h01, "R3 Apr30 end"); busRead(3'd6, 8'h05, "R3 to May"); idle(2);
    // R3 thirty-one-day month 05 does not wrap at 30
    setTime(8'h20, 8'h24, 8'h05, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59);
    pulse(); idle(3);
    busRead(3'd5, 8'h31, "R3 May31"); idle(2);

    // R4 year 99 into the next century
    setTime(8'h20, 8'h99, 8'h12, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59);
    pulse(); idle(3);
    readAll(8'h21, 8'h00, 8'h01, 8'h01, 8'h06, 8'h00, 8'h00, 8'h00, "R4 century carry");
    // R4 century 39 wraps to 00
    setTime(8'h39, 8'h99, 8'h12, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59);
    pulse(); idle(3);
    readAll(8'h00, 8'h00, 8'h01, 8'h01, 8'h06, 8'h00, 8'h00, 8'h00, "R4 century wrap");

    // R8 read-hold freezes the snapshot
    busWrite(3'd0, 8'h40); idle(2);
    pulse(); idle(2); pulse(); idle(3);
    busRead(3'd1, 8'h00, "R8 frozen seconds");
    busRead(3'd0, 8'h40, "R8 R7 control with read-hold"); idle(2);
    busWrite(3'd0, 8'h00); idle(3);
    busRead(3'd1, 8'h02, "R8 snapshot follows again"); idle(2);

    // R9 time-field write without write-hold is ignored
    busWrite(3'd1, 8'h30); idle(3);
    busRead(3'd1, 8'h02, "R9 ignored write"); idle(2);

    // R11 power fail blocks the bus, counting continues
    pwrGood = 1'b0;
    readNone(3'd1, "R11 no read data");
    busWrite(3'd0, 8'h80);
    addr = 17'h00100; chipSel = 1'b1; rdEn = 1'b1;
    #1 check("R11 ramSel blocked", {7'd0, ramSel}, 8'h00);
    @(negedge clk); chipSel = 1'b0; rdEn = 1'b0;
    pulse(); idle(2);
    pwrGood = 1'b1; idle(2);
    busRead(3'd1, 8'h03, "R11 counted during fail");
    busRead(3'd0, 8'h00, "R11 control write ignored"); idle(2);

    // R6 address below the window
    addr = 17'h00100; chipSel = 1'b1; rdEn = 1'b1;
    #1 check("R6 ramSel low address", {7'd0, ramSel}, 8'h01);
    @(negedge clk); chipSel = 1'b0; rdEn = 1'b0;
    #1 check("R6 no data for low address", {7'd0, dataOe}, 8'h00);
    addr = 17'h1FFF7; chipSel = 1'b1;
    #1 check("R6 ramSel just below window", {7'd0, ramSel}, 8'h01);
    addr = WIN; 
    #1 check("R6 ramSel low in window", {7'd0, ramSel}, 8'h00);
    chipSel = 1'b0;
    idle(4);
    check("R7 all reads answered", 8'(expQ.size()), 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule